// File: doc/BRIEF.md
# Shared-Adder Multichannel Sigma-Delta DAC

This block drives many single-bit sigma-delta outputs from one adder. It keeps each channel's 8-bit accumulator and 8-bit setpoint in small memories instead of in per-channel flip-flops. A channel counter visits the channels in a fixed cyclic order, one channel per clock. For the visited channel the block reads both stored words, adds them, writes the low byte back and stores the carry in that channel's output flip-flop. Each output therefore carries the same pulse-density stream that a dedicated first-order modulator would produce, but it is updated at the clock rate divided by the channel count. An external analog low-pass filter turns the stream into a level.

A host sets a channel's level through a one-cycle write strobe with a channel number and a setpoint. After reset the block clears both memories, one entry per clock, before it starts modulating. It holds every output low during that clearing pass.

Top module: `sdm_bank`

## Requirements
- R1: While reset is held and through the N-cycle clearing pass that follows its release, every output is 0. The first output update, for channel 0, happens at the (N+2)-th rising edge after release.
- R2: Channel c is read at rising edge N+1+v*N+c after reset release (v = 0, 1, 2, ...). Its output flip-flop can change only at the edge that follows that read, and all other output flip-flops hold at that edge.
- R3: At each visit the new output bit is the carry out of the 8-bit sum of accumulator plus setpoint, and the accumulator keeps the low 8 bits. Over any 256 consecutive visits with a constant setpoint s, the channel outputs exactly s ones.
- R4: A host write (wrEn high, channel wrChan, value wrData) stores the setpoint at the rising edge where wrEn is sampled. If that same edge is the read edge of that channel, the visit uses the old setpoint and the new one applies from the next visit.
- R5: Host writes sampled during the clearing pass are ignored, and the setpoint of that channel stays 0.
- R6: A setpoint of 0 keeps an output permanently low. A setpoint of 255 gives 255 ones in every 256 visits.
- R7: A reset asserted during operation clears all accumulators and setpoints again, so every output stays low afterwards until the host writes a new setpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host setpoint write strobe |
| wrChan | input | $clog2(NUM_CH) | Channel addressed by the write |
| wrData | input | ACC_W | New setpoint |
| dacOut | output | NUM_CH | One pulse-density output per channel |

## Verification
Two functions can fall in the same clock edge on the same channel. One is a host setpoint write; the other is the memory read that starts that channel's visit. The bench provokes the collision by waiting until the next edge is the read slot of the chosen channel and raising wrEn for exactly that edge. The visit must still add the old setpoint (0, so its output bit stays 0), and the visit after it must use the new one. A reference model judges every cycle's output vector. The same pairing is tested again with writes that land during the reset clearing pass, which must lose to the clear.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  // Phase of the channel sequencer
  typedef enum logic {
    ST_SWEEP = 1'b0,
    ST_RUN   = 1'b1
  } sdmState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clr;    // zero both memories at curAddr
    logic rdEn;   // read state of channel curAddr into the pipeline
    logic updEn;  // write back sum and latch carry for updAddr
  } sdmStrb_t;

endpackage

// File: rtl/sdm_ctrl.sv
module sdm_ctrl
  import sdm_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  output sdmStrb_t        strb,
  output logic [CH_W-1:0] curAddr,
  output logic [CH_W-1:0] updAddr
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  sdmState_t       state;
  logic [CH_W-1:0] chanCnt;
  logic            updEnQ;
  logic [CH_W-1:0] updAddrQ;
  logic            atLast;

  assign atLast = (chanCnt == LAST_CH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SWEEP;
      chanCnt  <= '0;
      updEnQ   <= 1'b0;
      updAddrQ <= '0;
    end else begin
      chanCnt  <= atLast ? '0 : chanCnt + 1'b1;
      if (state == ST_SWEEP && atLast) begin
        state <= ST_RUN;
      end
      updEnQ   <= (state == ST_RUN);
      updAddrQ <= chanCnt;
    end
  end

  always_comb begin
    strb.clr   = (state == ST_SWEEP);
    strb.rdEn  = (state == ST_RUN);
    strb.updEn = updEnQ;
  end

  assign curAddr = chanCnt;
  assign updAddr = updAddrQ;

endmodule

// File: rtl/sdm_datapath.sv
module sdm_datapath
  import sdm_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ACC_W  = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdmStrb_t          strb,
  input  logic [CH_W-1:0]   curAddr,
  input  logic [CH_W-1:0]   updAddr,
  input  logic              wrEn,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [ACC_W-1:0]  wrData,
  output logic [NUM_CH-1:0] dacOut
);

  logic [ACC_W-1:0] accMem [NUM_CH];
  logic [ACC_W-1:0] setMem [NUM_CH];
  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] setQ;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, accQ} + {1'b0, setQ};

  // Memories: clear pass has priority; otherwise write-back, host write
  // and registered read. The write-back and the read never share an address.
  always_ff @(posedge clk) begin
    if (strb.clr) begin
      accMem[curAddr] <= '0;
      setMem[curAddr] <= '0;
    end else begin
      if (strb.updEn) begin
        accMem[updAddr] <= sum[ACC_W-1:0];
      end
      if (wrEn) begin
        setMem[wrChan] <= wrData;
      end
      if (strb.rdEn) begin
        accQ <= accMem[curAddr];
        setQ <= setMem[curAddr];
      end
    end
  end

  // One output flip-flop per channel, loaded only in its own slot
  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_out
    logic bitQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bitQ <= 1'b0;
      end else if (strb.updEn && (updAddr == CH_W'(gi))) begin
        bitQ <= sum[ACC_W];
      end
    end
    assign dacOut[gi] = bitQ;
  end

endmodule

// File: rtl/sdm_bank.sv
module sdm_bank
  import sdm_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ACC_W  = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [ACC_W-1:0]  wrData,
  output logic [NUM_CH-1:0] dacOut
);

  sdmStrb_t        strb;
  logic [CH_W-1:0] curAddr;
  logic [CH_W-1:0] updAddr;

  sdm_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .curAddr (curAddr),
    .updAddr (updAddr)
  );

  sdm_datapath #(.NUM_CH(NUM_CH), .ACC_W(ACC_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .curAddr (curAddr),
    .updAddr (updAddr),
    .wrEn    (wrEn),
    .wrChan  (wrChan),
    .wrData  (wrData),
    .dacOut  (dacOut)
  );

endmodule

// File: rtl/sdm_bank_chk.sv
module sdm_bank_chk #(
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] dacOut,
  input logic              rdEn,
  input logic              updEn,
  input logic [CH_W-1:0]   curAddr,
  input logic [CH_W-1:0]   updAddr
);

  localparam int LIM = NUM_CH + 2;

  logic [CH_W+1:0] sinceRst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sinceRst <= '0;
    end else if (sinceRst < (CH_W+2)'(LIM)) begin
      sinceRst <= sinceRst + 1'b1;
    end
  end

  // R1
  sweep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceRst <= (CH_W+2)'(NUM_CH + 1)) |-> (dacOut == '0));

  // R2
  hold_outside_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !updEn |=> $stable(dacOut));

  // R2
  single_bit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updEn |=> ($countones(dacOut ^ $past(dacOut)) <= 1));

  // R2
  read_then_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdEn |=> (updEn && updAddr == $past(curAddr)));

endmodule

bind sdm_bank sdm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dacOut  (dacOut),
  .rdEn    (strb.rdEn),
  .updEn   (strb.updEn),
  .curAddr (curAddr),
  .updAddr (updAddr)
);

// File: tb/sim_sdm_bank.sv
module sim_sdm_bank;

  localparam int N  = 16;
  localparam int W  = 8;
  localparam int CW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrEn = 1'b0;
  logic [CW-1:0] wrChan = '0;
  logic [W-1:0]  wrData = '0;
  logic [N-1:0]  dacOut;

  always #4 clk = ~clk;  // 125 MHz

  sdm_bank #(.NUM_CH(N), .ACC_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn),
    .wrChan(wrChan), .wrData(wrData), .dacOut(dacOut)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string curReq = "R1";

  // ---------------- reference model + scoreboard ----------------
  typedef struct {
    logic [N-1:0] v;
    string        req;
  } item_t;
  item_t sbQ[$];
  item_t it;

  int mAcc[N];
  int mSet[N];
  logic [N-1:0] mOut;
  int cyc = 0;
  bit updPend;
  int updCh;
  logic updBit;

  always @(posedge clk) begin
    int c;
    int s;
    if (!rst_n) begin
      cyc = 0;
      updPend = 0;
      mOut = '0;
      for (int i = 0; i < N; i++) begin
        mAcc[i] = 0;
        mSet[i] = 0;
      end
      sbQ.delete();
    end else begin
      cyc++;
      if (updPend) mOut[updCh] = updBit;   // R2: output changes one edge after the read
      updPend = 0;
      if (cyc >= N + 1) begin
        c = (cyc - N - 1) % N;
        s = mAcc[c] + mSet[c];             // R3: carry of acc + setpoint
        mAcc[c] = s % 256;
        updBit = (s >= 256);
        updCh = c;
        updPend = 1;
      end
      // R4: read at this edge already used the old value; R5: sweep drops writes
      if (wrEn && cyc >= N + 1) mSet[wrChan] = int'(wrData);
      sbQ.push_back('{mOut, curReq});
    end
  end

  always @(negedge clk) begin
    if (rst_n && sbQ.size() > 0) begin
      it = sbQ.pop_front();
      compared++;
      if (dacOut !== it.v) begin
        mismatched++;
        $display("FAIL %s: cycle %0d dacOut=%h expected %h", it.req, cyc, dacOut, it.v);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic hostWrite(input int ch, input int val);
    @(posedge clk); #2;
    wrEn = 1'b1; wrChan = CW'(ch); wrData = W'(val);
    @(posedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic doReset(input int n);
    @(posedge clk); #2;
    rst_n = 1'b0;
    cycles(n);
    rst_n = 1'b1;
  endtask

  int spTab[N];

  task automatic measureDensity();
    int ones[N];
    int u;
    for (int i = 0; i < N; i++) ones[i] = 0;
    cycles(2 * N + 4);
    repeat (256 * N) begin
      @(negedge clk);
      u = (cyc - N - 2) % N;
      ones[u] += int'(dacOut[u]);
    end
    for (int i = 0; i < N; i++) begin
      compared++;
      if (ones[i] != spTab[i]) begin
        mismatched++;
        $display("FAIL %s: channel %0d ones=%0d expected %0d",
                 (spTab[i] == 0 || spTab[i] == 255) ? "R6" : "R3", i, ones[i], spTab[i]);
      end
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  // ---------------- stimulus ----------------
  initial begin
    // R1: reset state
    cycles(5);
    check("R1", dacOut, '0);
    @(posedge clk); #2;
    rst_n = 1'b1;

    // R5: writes during the clearing pass must be dropped
    curReq = "R5";
    hostWrite(3, 200);
    hostWrite(7, 255);
    @(negedge clk);
    check("R1", dacOut, '0);
    cycles(4 * N);
    @(negedge clk);
    check("R5", dacOut, '0);

    // R3 / R6: pulse density over 256 visits
    curReq = "R3";
    for (int i = 0; i < N; i++) spTab[i] = (i * 29 + 5) % 256;
    spTab[0] = 0;
    spTab[1] = 255;
    spTab[2] = 128;
    spTab[3] = 1;
    for (int i = 0; i < N; i++) hostWrite(i, spTab[i]);
    measureDensity();

    // R2: rapid, irregular writes across channels; model checks every cycle
    curReq = "R2";
    for (int k = 0; k < 200; k++) begin
      hostWrite((k * 7) % N, (k * 37 + 11) % 256);
      cycles(k % 3);
    end
    cycles(3 * N);

    // R4: write landing on the channel's own read edge
    curReq = "R4";
    hostWrite(5, 0);
    cycles(2 * N);
    forever begin
      if (((cyc - N) % N) == 5) break;   // next edge reads channel 5
      @(posedge clk); #2;
    end
    wrEn = 1'b1; wrChan = CW'(5); wrData = 8'd255;
    @(posedge clk); #2;
    wrEn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R4", N'(dacOut[5]), '0);
    cycles(6 * N);

    // R7: reset during operation clears all state again
    curReq = "R7";
    doReset(3);
    cycles(3 * N);
    repeat (2 * N) begin
      @(negedge clk);
      check("R7", dacOut, '0);
    end
    hostWrite(2, 128);
    cycles(8 * N);

    finishRun();
  end

endmodule